// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a logical address, made of a segment number and an offset inside that segment, into a physical address. Software fills a 16-entry segment table through a write port. Each entry holds a physical base, an offset limit, a valid bit and three permission bits for read, write and instruction fetch.

Each request carries an access kind. The unit looks up the segment's entry and checks three things in order: that the entry is valid, that the offset is within the limit, and that the access kind is permitted. If all three pass, it adds the base to the offset. One clock edge after the request, it returns either the physical address or a fault code.

Top module: `seg_xlate`

## Requirements
- R1: During and after reset, `rsp_valid` is 0, `rsp_fault` is 0 and `rsp_paddr` is 0, and every table entry is invalid.
- R2: A request that passes all checks returns `rsp_fault` = 0 and `rsp_paddr` = (base + zero-extended offset) modulo 2^24.
- R3: A request to an entry whose valid bit is 0 returns `rsp_fault` = 1.
- R4: A request whose offset is greater than the entry's limit returns `rsp_fault` = 2. The limit is the highest legal offset, so an offset equal to the limit is legal.
- R5: The `tbl_perm` bits are assigned as follows: bit 0 allows read, bit 1 allows write and bit 2 allows fetch. The `req_kind` encoding is 0 for read, 1 for write and 2 for fetch. Kind 3 is never permitted. A request whose kind is not permitted returns `rsp_fault` = 3.
- R6: When several checks fail, the reported code follows this priority: invalid (1) first, then bound (2), then permission (3).
- R7: Whenever `rsp_fault` is nonzero, `rsp_paddr` is 0.
- R8: When `tbl_we` is 1, the entry at `tbl_idx` takes all written fields at the clock edge. When `tbl_we` is 0, the table does not change.
- R9: A request in the same cycle as a write to the same entry is checked against the entry's contents from before the write.
- R10: `rsp_valid` is 1 exactly one cycle after a cycle with `req_valid` high. After a cycle without a request, `rsp_valid`, `rsp_fault` and `rsp_paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | 4 | Entry to write |
| tbl_base | input | 24 | Physical base to store |
| tbl_limit | input | 16 | Highest legal offset to store |
| tbl_valid | input | 1 | Valid bit to store |
| tbl_perm | input | 3 | Permission bits to store (fetch, write, read) |
| req_valid | input | 1 | Request present |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Registered response valid |
| rsp_paddr | output | 24 | Physical address, or 0 on a fault |
| rsp_fault | output | 2 | Fault code: 0 none, 1 invalid, 2 bound, 3 permission |

## Verification
The assertions assume that every request input is a known value in each cycle where `req_valid` is high. They also assume that the offset is narrower than the physical address, so that the zero-extended addition is well defined. The bench drives all inputs to defined values on every falling edge and keeps the parameters at their defaults. Its stimulus includes offsets placed exactly at the limit and one past it, every access kind including the unused code 3, and writes that hit the entry being looked up in the same cycle.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W  = 4,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [SEG_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [OFF_W-1:0]  tbl_limit,
  input  logic              tbl_valid,
  input  logic [2:0]        tbl_perm,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault
);
  localparam int NSEG = 1 << SEG_W;

  logic [ADDR_W-1:0] base_q [NSEG];
  logic [OFF_W-1:0]  lim_q  [NSEG];
  logic [2:0]        perm_q [NSEG];
  logic [NSEG-1:0]   vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (tbl_we) begin
      vld_q[tbl_idx]  <= tbl_valid;
      base_q[tbl_idx] <= tbl_base;
      lim_q[tbl_idx]  <= tbl_limit;
      perm_q[tbl_idx] <= tbl_perm;
    end
  end

  wire [ADDR_W-1:0] e_base = base_q[req_seg];
  wire [OFF_W-1:0]  e_lim  = lim_q[req_seg];
  wire [2:0]        e_perm = perm_q[req_seg];
  wire              e_vld  = vld_q[req_seg];

  wire perm_ok = (req_kind != 2'd3) && e_perm[req_kind];

  wire [1:0] fault_d = !e_vld            ? 2'd1 :
                       (req_off > e_lim) ? 2'd2 :
                       !perm_ok          ? 2'd3 : 2'd0;

  wire [ADDR_W-1:0] sum_d = e_base + ADDR_W'(req_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 2'd0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? fault_d : 2'd0;
      rsp_paddr <= (req_valid && fault_d == 2'd0) ? sum_d : '0;
    end
  end

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 2'd0 && rsp_paddr == '0));

  // R7
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  // R3
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !e_vld) |=> (rsp_fault == 2'd1));

  // R4
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && e_vld && req_off > e_lim) |=> (rsp_fault == 2'd2));
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [23:0] tbl_base = '0;
  logic [15:0] tbl_limit = '0;
  logic        tbl_valid = 1'b0;
  logic [2:0]  tbl_perm = '0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [23:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  always #10 clk = ~clk;

  seg_xlate u_dut (.*);

  int          compared = 0, mismatched = 0;
  bit          done = 1'b0;
  int          m_base [16];
  int          m_lim  [16];
  bit [2:0]    m_perm [16];
  bit          m_vld  [16];
  bit          have_exp = 1'b0;
  bit          x_valid;
  int          x_fault, x_paddr;
  string       x_tag;

  task automatic compare_now();
    if (!have_exp) return;
    compared++;
    if (rsp_valid !== x_valid || int'(rsp_fault) != x_fault || int'(rsp_paddr) != x_paddr) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b fault=%0d paddr=%h, expected valid=%0b fault=%0d paddr=%h",
               x_tag, rsp_valid, rsp_fault, rsp_paddr, x_valid, x_fault, x_paddr);
    end
  endtask

  task automatic step(string tag, bit we, int idx, int base, int lim, bit vld, bit [2:0] perm,
                      bit rv, int seg, int off, int kind);
    @(negedge clk);
    compare_now();
    tbl_we = we; tbl_idx = 4'(idx); tbl_base = 24'(base); tbl_limit = 16'(lim);
    tbl_valid = vld; tbl_perm = perm;
    req_valid = rv; req_seg = 4'(seg); req_off = 16'(off); req_kind = 2'(kind);
    x_tag = tag; x_valid = rv; x_fault = 0; x_paddr = 0;
    if (rv) begin
      if (!m_vld[seg]) x_fault = 1;
      else if (off > m_lim[seg]) x_fault = 2;
      else if (kind == 3 || !m_perm[seg][kind]) x_fault = 3;
      else x_paddr = (m_base[seg] + off) & 32'hFFFFFF;
    end
    have_exp = 1'b1;
    if (we) begin
      m_base[idx] = base & 32'hFFFFFF; m_lim[idx] = lim & 32'hFFFF;
      m_vld[idx] = vld; m_perm[idx] = perm;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_lim[i] = 0; m_vld[i] = 0; m_perm[i] = 0; end
    repeat (3) @(negedge clk);
    compared++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 2'd0 || rsp_paddr !== 24'd0) begin
      mismatched++;
      $display("FAIL R1: got valid=%0b fault=%0d paddr=%h, expected 0/0/0", rsp_valid, rsp_fault, rsp_paddr);
    end
    rst_n = 1'b1;
    for (int s = 0; s < 16; s++) step("R1", 0, 0, 0, 0, 0, 0, 1, s, 0, 0);
    step("R8", 1, 3, 'h100000, 'h0FFF, 1, 3'b001, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 3, 'h10, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 3, 'h0FFF, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 3, 'h1000, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 3, 'h20, 1);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 3, 'h20, 2);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 3, 'h20, 3);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 3, 'h20, 0);
    step("R8", 1, 5, 'hFFFF00, 'hFFFF, 1, 3'b111, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 5, 'h200, 2);
    step("R8", 1, 6, 'h2000, 'h10, 1, 3'b000, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 6, 'h20, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 6, 'h10, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 7, 'hFFFF, 3);
    step("R8", 0, 3, 'h0, 'h0, 0, 3'b000, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 3, 'h0FFF, 0);
    step("R9", 1, 8, 'h4000, 'hFF, 1, 3'b010, 1, 8, 'h4, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 8, 'h4, 1);
    step("R9", 1, 8, 'h4000, 'hFF, 0, 3'b010, 1, 8, 'h4, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 8, 'h4, 1);
    for (int n = 0; n < 3000; n++) begin
      int lim = int'($urandom_range(0, 16'hFFFF));
      int seg = int'($urandom_range(0, 15));
      int off;
      case ($urandom_range(0, 3))
        0: off = m_lim[seg];
        1: off = m_lim[seg] + 1;
        default: off = int'($urandom_range(0, 16'hFFFF));
      endcase
      step("R2", $urandom_range(0, 3) == 0, int'($urandom_range(0, 15)),
           int'($urandom_range(0, 24'hFFFFFF)), lim, $urandom_range(0, 4) != 0,
           3'($urandom_range(0, 7)), $urandom_range(0, 4) != 0, seg, off & 'hFFFF,
           int'($urandom_range(0, 3)));
    end
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare_now();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule